// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block gives software control over 32 general-purpose pins through a small synchronous register bus. The pins are grouped into four banks of eight. Every bank has the same register layout at its own 64-byte window, so pin n is bit (n & 7) of bank (n >> 3). For example, pin 10 is bit 2 of bank 1 at base 0x40.

Each bank has a direction register, an output latch and a read-only view of the pin levels. Each bank also has an interrupt unit. The unit holds a raw pending register, a mask that has separate set and clear addresses, a masked pending view, and a per-pin choice between level and edge triggering. Pin inputs pass through a two-flop synchronizer before the input view and the event detectors use them. One interrupt output is the OR of every masked pending bit in all banks.

Register offsets inside a bank are:

| Offset | Register | Access |
|---|---|---|
| 0x00 | Masked pending | Read-only |
| 0x04 | Raw pending | Read; write 1 to clear |
| 0x08 | Mask | Read; write 1 to set |
| 0x0C | Mask clear | Write 1 to clear; reads 0 |
| 0x10 | Direction | Read/write |
| 0x14 | Output latch | Read/write |
| 0x18 | Pin levels | Read-only |
| 0x20 | Trigger mode | Read/write |

Only bits 7:0 of each register are used.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the following hold: direction is all ones (all inputs, so pin_oe is 0), the output latch is 0, the mask is 0xFF, raw pending is 0, trigger mode is 0 (edge), and irq_o is 0.
- R2: Bank b occupies addresses b*0x40 to b*0x40+0x3F. Pin n maps to bit (n & 7) of bank (n >> 3). Bits 31:8 of read data are always 0, and unused offsets read 0.
- R3: The direction register is at offset 0x10, where 1 means input, and pin_oe[n] is the inverse of the pin's direction bit. The output latch is at offset 0x14 and drives pin_out; both registers read back what was written.
- R4: Offset 0x18 reads the pin levels after a two-flop synchronizer. A pin change is first visible after the second rising clock edge. Writes to 0x18 have no effect.
- R5: When the trigger mode bit is 0, a rising edge of the synchronized pin sets the raw pending bit. The bit is first visible after the third clock edge following the pin change. A falling edge sets nothing.
- R6: When the trigger mode bit at offset 0x20 is 1, the raw pending bit is set on every cycle the synchronized pin is high. If the bit is cleared while the pin is high, it reads 1 again right after the clear.
- R7: Offset 0x04 reads raw pending. Writing it clears each bit written as 1 and leaves bits written as 0 unchanged. An event in the same cycle as a clear keeps the bit set.
- R8: Offset 0x08 reads the mask, and writing 1s there sets those mask bits. Writing 1s to offset 0x0C clears those mask bits, and reading 0x0C returns 0.
- R9: Offset 0x00 reads raw pending AND NOT mask. Writes to 0x00 have no effect.
- R10: irq_o is high exactly when any bank has a masked pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: bank in bits 7:6, offset in bits 5:0 |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |
| irq_o | output | 1 | Combined interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a mask-set or mask-clear write takes effect on the next cycle;
- a write-1 clear removes pending bits unless a new event arrives in the same cycle;
- an edge or a high level in its own mode always sets the pending bit;
- a pending bit never rises without an event.

Some behaviours only the directed scenarios can show:
- the address map across banks;
- the exact two-edge and three-edge latency from a pin change;
- that writes to the read-only views are ignored;
- a level-mode bit that sets again after a clear;
- how the mask gates irq_o across banks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_PEND_MSK = 6'h00;
    localparam logic [OFF_W-1:0] OFF_PEND_RAW = 6'h04;
    localparam logic [OFF_W-1:0] OFF_MASK_SET = 6'h08;
    localparam logic [OFF_W-1:0] OFF_MASK_CLR = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_DIR      = 6'h10;
    localparam logic [OFF_W-1:0] OFF_DOUT     = 6'h14;
    localparam logic [OFF_W-1:0] OFF_DIN      = 6'h18;
    localparam logic [OFF_W-1:0] OFF_TRIG     = 6'h20;

    // one-hot write strobes for one bank
    typedef struct packed {
        logic pend_clr;
        logic mask_set;
        logic mask_clr;
        logic dir;
        logic dout;
        logic trig;
    } bank_wr_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stab;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_wr_t         wr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W-1:0]     pin_sync_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output logic [W-1:0]     rd_data_o,
    output logic [W-1:0]     dout_o,
    output logic [W-1:0]     oe_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] mask;
        logic [W-1:0] raw;
        logic [W-1:0] trig;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [W-1:0] edge_ev, level_ev, set_vec, clr_vec, pend_msk;

    always_comb begin
        edge_ev  = pin_sync_i & ~st_q.prev & ~st_q.trig;
        level_ev = pin_sync_i & st_q.trig;
        set_vec  = edge_ev | level_ev;
        clr_vec  = wr_i.pend_clr ? wdata_i : '0;

        st_d      = st_q;
        st_d.prev = pin_sync_i;
        st_d.raw  = (st_q.raw & ~clr_vec) | set_vec;
        if (wr_i.dir)      st_d.dir  = wdata_i;
        if (wr_i.dout)     st_d.dout = wdata_i;
        if (wr_i.trig)     st_d.trig = wdata_i;
        if (wr_i.mask_set) st_d.mask = st_q.mask | wdata_i;
        if (wr_i.mask_clr) st_d.mask = st_q.mask & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dir  <= '1;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_msk = st_q.raw & ~st_q.mask;
    assign irq_o    = |pend_msk;
    assign dout_o   = st_q.dout;
    assign oe_o     = ~st_q.dir;

    always_comb begin
        case (rd_off_i)
            OFF_PEND_MSK: rd_data_o = pend_msk;
            OFF_PEND_RAW: rd_data_o = st_q.raw;
            OFF_MASK_SET: rd_data_o = st_q.mask;
            OFF_DIR:      rd_data_o = st_q.dir;
            OFF_DOUT:     rd_data_o = st_q.dout;
            OFF_DIN:      rd_data_o = pin_sync_i;
            OFF_TRIG:     rd_data_o = st_q.trig;
            default:      rd_data_o = '0;
        endcase
    end

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.mask_set |=> ((st_q.mask & $past(wdata_i)) == $past(wdata_i))); // R8
    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.mask_clr |=> ((st_q.mask & $past(wdata_i)) == '0)); // R8
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.pend_clr |=> ((st_q.raw & $past(wdata_i & ~set_vec)) == '0)); // R7
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev != '0) |=> ((st_q.raw & $past(edge_ev)) == $past(edge_ev))); // R5
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_ev != '0) |=> ((st_q.raw & $past(level_ev)) == $past(level_ev))); // R6
    AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & ~$past(st_q.raw) & ~$past(set_vec)) == '0)); // R5

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int  N_BANK = 4,
    parameter int  BANK_W = 8,
    parameter int  DATA_W = 32,
    localparam int SEL_W  = $clog2(N_BANK),
    localparam int ADDR_W = OFF_W + SEL_W,
    localparam int N_PINS = N_BANK * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq_o
);

    logic [N_PINS-1:0] pin_sync;
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic [BANK_W-1:0] bank_rd [N_BANK];
    logic [N_BANK-1:0] bank_irq;
    bank_wr_t          strobe;

    assign sel = bus_addr[ADDR_W-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    always_comb begin
        strobe          = '0;
        strobe.pend_clr = bus_we && (off == OFF_PEND_RAW);
        strobe.mask_set = bus_we && (off == OFF_MASK_SET);
        strobe.mask_clr = bus_we && (off == OFF_MASK_CLR);
        strobe.dir      = bus_we && (off == OFF_DIR);
        strobe.dout     = bus_we && (off == OFF_DOUT);
        strobe.trig     = bus_we && (off == OFF_TRIG);
    end

    gpio_sync2 #(.W(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        bank_wr_t wr_b;
        assign wr_b = (sel == SEL_W'(b)) ? strobe : '0;

        gpio_bank #(.W(BANK_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr_b),
            .wdata_i    (bus_wdata[BANK_W-1:0]),
            .pin_sync_i (pin_sync[b*BANK_W +: BANK_W]),
            .rd_off_i   (off),
            .rd_data_o  (bank_rd[b]),
            .dout_o     (pin_out[b*BANK_W +: BANK_W]),
            .oe_o       (pin_oe[b*BANK_W +: BANK_W]),
            .irq_o      (bank_irq[b])
        );
    end

    always_comb begin
        bus_rdata               = '0;
        bus_rdata[BANK_W-1:0]   = bank_rd[sel];
    end

    assign irq_o = |bank_irq;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o); // R1

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1", "pin_oe", pin_oe, 32'h0);
        chk("R1", "pin_out", pin_out, 32'h0);
        chk("R1", "irq", {31'b0, irq_o}, 32'h0);
        rd(8'h10, v); chk("R1", "dir b0", v, 32'hFF);
        rd(8'hC8, v); chk("R1", "mask b3", v, 32'hFF);
        rd(8'h44, v); chk("R1", "raw b1", v, 32'h0);
        rd(8'hA0, v); chk("R1", "trig b2", v, 32'h0);
        rd(8'h94, v); chk("R1", "dout b2", v, 32'h0);
    endtask

    task automatic t_dir_out;
        logic [31:0] v;
        wr(8'h50, 32'hFFFF_FFF0);
        chk("R3", "oe bank1", pin_oe, 32'h0000_0F00);
        rd(8'h50, v); chk("R2", "dir upper bits zero", v, 32'h0000_00F0);
        wr(8'h54, 32'h0000_0004);
        chk("R2", "pin 10 is bank1 bit2", pin_out, 32'h0000_0400);
        wr(8'hD4, 32'h0000_00A5);
        chk("R3", "dout bank3", pin_out, 32'hA500_0400);
        rd(8'hD4, v); chk("R3", "dout readback", v, 32'hA5);
        rd(8'h7C, v); chk("R2", "unused offset", v, 32'h0);
        wr(8'h50, 32'hFF);
        chk("R3", "oe back off", pin_oe, 32'h0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 8'hD8;
        pin_in[26] = 1'b1;
        @(posedge clk); #1 chk("R4", "after 1 edge", bus_rdata, 32'h0);
        @(posedge clk); #1 chk("R4", "after 2 edges", bus_rdata, 32'h04);
        wr(8'hD8, 32'h0);
        rd(8'hD8, v); chk("R4", "write to input ignored", v, 32'h04);
        pin_in[26] = 1'b0;
        repeat (3) @(posedge clk);
        wr(8'hC4, 32'hFF);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(8'h0C, 32'h01);
        rd(8'h08, v); chk("R8", "mask cleared bit0", v, 32'hFE);
        rd(8'h0C, v); chk("R8", "mask-clr reads 0", v, 32'h0);
        @(negedge clk);
        bus_addr = 8'h04;
        pin_in[0] = 1'b1;
        @(posedge clk); #1 chk("R5", "raw edge1", bus_rdata, 32'h0);
        @(posedge clk); #1 chk("R5", "raw edge2", bus_rdata, 32'h0);
        chk("R10", "irq not yet", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1 chk("R5", "raw edge3", bus_rdata, 32'h1);
        chk("R10", "irq up", {31'b0, irq_o}, 32'h1);
        rd(8'h00, v); chk("R9", "masked pend", v, 32'h1);
        wr(8'h00, 32'hFF);
        rd(8'h00, v); chk("R9", "write masked ignored", v, 32'h1);
        wr(8'h04, 32'hFE);
        rd(8'h04, v); chk("R7", "zero bits keep", v, 32'h1);
        wr(8'h04, 32'h01);
        rd(8'h04, v); chk("R7", "w1c clears", v, 32'h0);
        chk("R10", "irq down", {31'b0, irq_o}, 32'h0);
        pin_in[0] = 1'b0;
        repeat (4) @(posedge clk);
        rd(8'h04, v); chk("R5", "falling edge sets nothing", v, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(8'hA0, 32'h01);
        rd(8'hA0, v); chk("R6", "trig readback", v, 32'h01);
        @(negedge clk);
        pin_in[16] = 1'b1;
        repeat (3) @(posedge clk);
        rd(8'h84, v); chk("R6", "level sets", v, 32'h01);
        wr(8'h84, 32'h01);
        rd(8'h84, v); chk("R6", "re-set while high", v, 32'h01);
        pin_in[16] = 1'b0;
        repeat (3) @(posedge clk);
        wr(8'h84, 32'h01);
        rd(8'h84, v); chk("R6", "stays clear when low", v, 32'h0);
        chk("R10", "masked level no irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] v;
        wr(8'h08, 32'h01);
        rd(8'h08, v); chk("R8", "mask set", v, 32'hFF);
        @(negedge clk);
        pin_in[31] = 1'b1;
        repeat (3) @(posedge clk);
        rd(8'hC4, v); chk("R9", "raw bank3", v, 32'h80);
        rd(8'hC0, v); chk("R9", "masked bank3 hidden", v, 32'h0);
        chk("R10", "masked no irq", {31'b0, irq_o}, 32'h0);
        wr(8'hCC, 32'h80);
        chk("R10", "bank3 irq", {31'b0, irq_o}, 32'h1);
        rd(8'h00, v); chk("R2", "bank0 masked unaffected", v, 32'h0);
        wr(8'hC8, 32'h80);
        chk("R10", "remasked", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_out();
        t_input();
        t_edge();
        t_level();
        t_mask_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule